// File: doc/BRIEF.md
# Single-Cycle Load/Store Datapath with Stuck-At Fault Override

This block is a 32-bit processor datapath that completes one instruction per clock. Each instruction is fetched, decoded, executed and written back in the same cycle. The supported instructions are register-to-register arithmetic and logic, add-immediate, word load, word store, branch on equal and branch on not equal. A small instruction array is filled through a write port while the core is held in reset. A small data array sits inside the block. The state of each cycle is visible on the outputs: the program counter, the current instruction, the register write, the memory write and the branch decision.

A fault port can override four internal nets with a constant value. These nets are the destination-register select, the ALU second-operand select, the write-back source select and the ALU zero flag. Each net has a force bit and a value bit, and each is overridden independently of the others. A test program run under a chosen override shows which instruction classes still give correct results and which do not.

Top module: `scdp_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC goes to 0, every register and every data-memory word is cleared, and `rf_we_o` and `dm_we_o` stay low.
- R2: When no branch is taken, the PC advances by 4 each clock. The instruction executed is instruction-array word `pc[7:2]`.
- R3: Opcode 000000 with funct add 100000, sub 100010, and 100100, or 100101 or signed set-less-than 101010 writes the result of rs op rt into the register named by bits 15:11.
- R4: Opcode 001000 (add immediate) writes rs plus the sign-extended bits 15:0 into the register named by bits 20:16.
- R5: Opcode 101011 stores rt at word address (rs + sext(imm)) and writes no register. Opcode 100011 loads that word into the register named by bits 20:16.
- R6: Opcode 000100 branches when rs equals rt, and opcode 000101 branches when they differ. A taken branch sets the next PC to PC+4+(sext(imm)<<2), and `br_taken_o` is high in that cycle.
- R7: Register 0 always reads as zero, and writes to it are dropped.
- R8: Any other opcode, or an R-type funct not listed in R3, writes neither a register nor memory. It only advances the PC.
- R9: Fault index 0 is the destination select (1 selects bits 15:11) and index 1 is the operand select (1 selects the immediate). When `flt_force[i]` is high, `flt_value[i]` replaces net i. When `flt_force[i]` is low, `flt_value[i]` has no effect.
- R10: Fault index 2 is the write-back select (1 selects memory data) and index 3 is the ALU zero flag. Both are overridden with the same force/value rule as R9. A zero flag held high makes every beq taken and every bne not taken. A zero flag held low does the opposite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_we | input | 1 | Instruction array write strobe |
| imem_addr | input | IMEM_AW | Instruction array word index |
| imem_wdata | input | 32 | Instruction word to store |
| flt_force | input | 4 | Per-net override enable (0 dst sel, 1 operand sel, 2 write-back sel, 3 zero) |
| flt_value | input | 4 | Per-net override value |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 32 | Write-back data |
| dm_we_o | output | 1 | Data memory write this cycle |
| dm_addr_o | output | 32 | ALU result / data byte address |
| dm_wdata_o | output | 32 | Store data (rt) |
| br_taken_o | output | 1 | Branch taken this cycle |

## Verification
The arithmetic program uses a negative immediate and operand pairs of mixed sign. This separates sign extension from zero extension, and signed comparison from unsigned comparison. It also checks that results land in bits 15:11 and not in bits 20:16. The branch program takes beq and bne on equal and on unequal operands, so the condition cannot be confused with its inverse. A store followed by a load, and a re-run after reset, separate the data path of the memory from its clearing. Each stuck-at value is run on a program in which it changes a visible destination, operand, write-back value or PC. A run with all force bits low and all value bits high shows that the value bits do nothing on their own.

// File: rtl/scdp_pkg.sv
// Package: shared encodings, control word and fault helpers for the
// single-cycle datapath. Assumes a 32-bit word and 5-bit register fields.
package scdp_pkg;

    localparam int unsigned XLEN = 32;
    localparam int unsigned RIDX = 5;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_BNE   = 6'b000101;
    localparam logic [5:0] OP_ADDI  = 6'b001000;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // Fault port bit positions
    localparam int unsigned FI_DSTSEL = 0;
    localparam int unsigned FI_OPBSEL = 1;
    localparam int unsigned FI_WBSEL  = 2;
    localparam int unsigned FI_ZERO   = 3;
    localparam int unsigned N_FAULT   = 4;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic    dst_sel;   // 1: rd (15:11), 0: rt (20:16)
        logic    opb_sel;   // 1: extended immediate, 0: rt value
        logic    wb_sel;    // 1: data memory, 0: ALU result
        logic    reg_wr;
        logic    mem_wr;
        logic    branch;
        logic    br_ne;     // 1: branch on not-equal
        alu_op_e alu_op;
    } ctrl_t;

    // Replace a net by a constant when its force bit is set
    function automatic logic stuck(input logic n, input logic frc, input logic val);
        return frc ? val : n;
    endfunction

endpackage

// File: rtl/scdp_decode.sv
// Module: opcode/funct decoder. Produces the control word as a pure
// function of the instruction fields. Unsupported codes yield a word with
// every write and branch strobe low.
module scdp_decode
    import scdp_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);

    // Decode opcode and, for R-type, the function code
    always_comb begin
        ctl        = '0;
        ctl.alu_op = ALU_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                ctl.dst_sel = 1'b1;
                ctl.reg_wr  = 1'b1;
                unique case (funct)
                    FN_ADD:  ctl.alu_op = ALU_ADD;
                    FN_SUB:  ctl.alu_op = ALU_SUB;
                    FN_AND:  ctl.alu_op = ALU_AND;
                    FN_OR:   ctl.alu_op = ALU_OR;
                    FN_SLT:  ctl.alu_op = ALU_SLT;
                    default: ctl.reg_wr = 1'b0;
                endcase
            end
            OP_LW: begin
                ctl.opb_sel = 1'b1;
                ctl.wb_sel  = 1'b1;
                ctl.reg_wr  = 1'b1;
            end
            OP_SW: begin
                ctl.opb_sel = 1'b1;
                ctl.mem_wr  = 1'b1;
            end
            OP_ADDI: begin
                ctl.opb_sel = 1'b1;
                ctl.reg_wr  = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                ctl.alu_op = ALU_SUB;
            end
            OP_BNE: begin
                ctl.branch = 1'b1;
                ctl.br_ne  = 1'b1;
                ctl.alu_op = ALU_SUB;
            end
            default: ;
        endcase
    end

    // R8: no instruction both writes and branches
    always_comb begin
        p_ctrl_excl_r8: assert ($onehot0({ctl.reg_wr, ctl.mem_wr, ctl.branch}))
            else $error("decoder raised more than one strobe");
    end

endmodule

// File: rtl/scdp_alu.sv
// Module: combinational ALU. Add, subtract, bitwise and/or, signed
// set-less-than. The zero flag reflects the raw result.
module scdp_alu
    import scdp_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Select the operation result
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    // Zero detect on the result
    always_comb zero = (y == '0);

endmodule

// File: rtl/scdp_regfile.sv
// Module: register file, two asynchronous read ports and one write port
// committed on the rising edge. Entry 0 is hardwired to zero. Assumes the
// synchronous active-low reset may clear every entry.
module scdp_regfile #(
    parameter int unsigned W    = 32,
    parameter int unsigned NREG = 32,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs_q [NREG];

    // Clear on reset, otherwise commit the write unless it targets entry 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs_q[waddr] <= wdata;
        end
    end

    // Read ports, entry 0 forced to zero
    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
    end

    // R7: entry 0 never holds a nonzero value
    p_r0_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we && (waddr == '0) |=> regs_q[0] == '0)
        else $error("register 0 took a write");

endmodule

// File: rtl/scdp_core.sv
// Module: single-cycle datapath top. Fetches from an internal instruction
// array, decodes, executes, accesses the internal data array and writes
// back within one clock. Four control/status nets can be forced to a
// constant through the fault port. Assumes the instruction array is
// loaded while rst_n is low.
module scdp_core
    import scdp_pkg::*;
#(
    parameter int unsigned IMEM_AW = 6,
    parameter int unsigned DMEM_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               imem_we,
    input  logic [IMEM_AW-1:0] imem_addr,
    input  logic [31:0]        imem_wdata,
    input  logic [3:0]         flt_force,
    input  logic [3:0]         flt_value,
    output logic [31:0]        pc_o,
    output logic [31:0]        instr_o,
    output logic               rf_we_o,
    output logic [4:0]         rf_waddr_o,
    output logic [31:0]        rf_wdata_o,
    output logic               dm_we_o,
    output logic [31:0]        dm_addr_o,
    output logic [31:0]        dm_wdata_o,
    output logic               br_taken_o
);

    localparam int unsigned IMEM_DEPTH = 1 << IMEM_AW;
    localparam int unsigned DMEM_DEPTH = 1 << DMEM_AW;
    localparam int unsigned NREG       = 1 << RIDX;

    logic [XLEN-1:0] pc_q, pc_plus4, br_off, pc_next;
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] imem_q [IMEM_DEPTH];
    logic [XLEN-1:0] dmem_q [DMEM_DEPTH];
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, opb, alu_y, dm_rdata, wb_data;
    logic [RIDX-1:0] waddr;
    logic            zero_raw, zero_f, br_taken, rf_we, dm_we;
    logic            dst_sel_f, opb_sel_f, wb_sel_f;
    ctrl_t           ctl;

    // Instruction array load port
    always_ff @(posedge clk) begin
        if (imem_we) imem_q[imem_addr] <= imem_wdata;
    end

    // Fetch by word index
    always_comb instr = imem_q[pc_q[IMEM_AW+1:2]];

    scdp_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl)
    );

    // Apply stuck-at overrides to the three select nets
    always_comb begin
        dst_sel_f = stuck(ctl.dst_sel, flt_force[FI_DSTSEL], flt_value[FI_DSTSEL]);
        opb_sel_f = stuck(ctl.opb_sel, flt_force[FI_OPBSEL], flt_value[FI_OPBSEL]);
        wb_sel_f  = stuck(ctl.wb_sel,  flt_force[FI_WBSEL],  flt_value[FI_WBSEL]);
    end

    scdp_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (waddr),
        .wdata   (wb_data),
        .raddr_a (instr[25:21]),
        .raddr_b (instr[20:16]),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    // Sign extension and second-operand mux
    always_comb begin
        imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
        opb     = opb_sel_f ? imm_ext : rt_val;
    end

    scdp_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (opb),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (zero_raw)
    );

    // Data array: cleared on reset, written on store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DMEM_DEPTH; i++) dmem_q[i] <= '0;
        end else if (dm_we) begin
            dmem_q[alu_y[DMEM_AW+1:2]] <= rt_val;
        end
    end

    // Asynchronous data read, write-back source and destination muxes
    always_comb begin
        dm_rdata = dmem_q[alu_y[DMEM_AW+1:2]];
        wb_data  = wb_sel_f ? dm_rdata : alu_y;
        waddr    = dst_sel_f ? instr[15:11] : instr[20:16];
        rf_we    = ctl.reg_wr & rst_n;
        dm_we    = ctl.mem_wr & rst_n;
    end

    // Branch decision with zero-flag override and next-PC selection
    always_comb begin
        zero_f   = stuck(zero_raw, flt_force[FI_ZERO], flt_value[FI_ZERO]);
        br_taken = ctl.branch & (ctl.br_ne ? ~zero_f : zero_f);
        pc_plus4 = pc_q + 32'd4;
        br_off   = {imm_ext[XLEN-3:0], 2'b00};
        pc_next  = br_taken ? (pc_plus4 + br_off) : pc_plus4;
    end

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    // Observation outputs
    always_comb begin
        pc_o       = pc_q;
        instr_o    = instr;
        rf_we_o    = rf_we;
        rf_waddr_o = waddr;
        rf_wdata_o = wb_data;
        dm_we_o    = dm_we;
        dm_addr_o  = alu_y;
        dm_wdata_o = rt_val;
        br_taken_o = br_taken;
    end

    // R1: reset returns the PC to zero
    p_pc_reset_r1: assert property (@(posedge clk)
        !rst_n |=> pc_q == '0)
        else $error("PC not cleared by reset");

    // R2: straight-line flow advances by one word
    p_pc_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken_o |=> pc_q == $past(pc_q) + 32'd4)
        else $error("PC did not advance by 4");

    // R5: a store never writes a register
    p_st_nowb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> !rf_we_o)
        else $error("store also wrote a register");

    // R9: destination select held low routes writes to bits 20:16
    p_flt_dst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flt_force[FI_DSTSEL] && !flt_value[FI_DSTSEL] && rf_we_o
        |-> rf_waddr_o == instr_o[20:16])
        else $error("destination override ignored");

endmodule

// File: tb/sim_scdp_core.sv
// Directed bench for scdp_core: one task per scenario, each checking its
// own results at the falling edge after inputs settle.
module sim_scdp_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_addr = '0;
    logic [31:0] imem_wdata = '0;
    logic [3:0]  flt_force = '0;
    logic [3:0]  flt_value = '0;
    logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic        rf_we_o, dm_we_o, br_taken_o;
    logic [4:0]  rf_waddr_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    scdp_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_we    (imem_we),
        .imem_addr  (imem_addr),
        .imem_wdata (imem_wdata),
        .flt_force  (flt_force),
        .flt_value  (flt_value),
        .pc_o       (pc_o),
        .instr_o    (instr_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o),
        .br_taken_o (br_taken_o)
    );

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic exp_wb(input string tag, input logic [4:0] a, input logic [31:0] d);
        chk({tag, " we"},    {31'd0, rf_we_o}, 32'd1);
        chk({tag, " waddr"}, {27'd0, rf_waddr_o}, {27'd0, a});
        chk({tag, " wdata"}, rf_wdata_o, d);
    endtask

    task automatic put(input int idx, input logic [31:0] w);
        @(negedge clk);
        imem_we    = 1'b1;
        imem_addr  = idx[5:0];
        imem_wdata = w;
        @(negedge clk);
        imem_we    = 1'b0;
    endtask

    // Hold reset, clear overrides and fill the array with no-op words
    task automatic restart();
        @(negedge clk);
        rst_n     = 1'b0;
        flt_force = '0;
        flt_value = '0;
        for (int i = 0; i < 64; i++) put(i, 32'h0);
    endtask

    task automatic go();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic load_branch_prog();
        put(0, enc_i(6'b001000, 0, 1, 16'd7));
        put(1, enc_i(6'b001000, 0, 2, 16'd7));
        put(2, enc_i(6'b000100, 1, 2, 16'd3));
        put(3, enc_i(6'b001000, 0, 9, 16'd1));
        put(4, enc_i(6'b001000, 0, 9, 16'd1));
        put(5, enc_i(6'b001000, 0, 9, 16'd1));
        put(6, enc_i(6'b000101, 1, 2, 16'd1));
        put(7, enc_i(6'b001000, 0, 3, 16'd1));
        put(8, enc_i(6'b000101, 1, 3, 16'd1));
        put(9, enc_i(6'b001000, 0, 9, 16'd1));
        put(10, enc_i(6'b000100, 1, 3, 16'd1));
    endtask

    // Arithmetic, memory, register-0 and unknown-opcode program
    task automatic t_arith();
        restart();
        put(0,  enc_i(6'b001000, 0, 1, 16'd5));
        put(1,  enc_i(6'b001000, 0, 2, 16'hFFFD));
        put(2,  enc_r(1, 2, 3, 6'b100000));
        put(3,  enc_r(1, 2, 4, 6'b100010));
        put(4,  enc_r(1, 2, 5, 6'b100100));
        put(5,  enc_r(1, 2, 6, 6'b100101));
        put(6,  enc_r(2, 1, 7, 6'b101010));
        put(7,  enc_r(1, 2, 7, 6'b101010));
        put(8,  enc_i(6'b101011, 1, 3, 16'd3));
        put(9,  enc_i(6'b100011, 0, 8, 16'd8));
        put(10, enc_i(6'b001000, 0, 0, 16'd9));
        put(11, enc_r(0, 0, 9, 6'b100000));
        put(12, 32'hFC00_0000);
        put(13, enc_r(1, 2, 10, 6'b000111));
        flt_value = 4'hF;   // R9: value bits without force bits
        @(negedge clk); #1;
        chk("R1 pc in reset", pc_o, 32'd0);
        chk("R1 no rf write in reset", {31'd0, rf_we_o}, 32'd0);
        chk("R1 no dm write in reset", {31'd0, dm_we_o}, 32'd0);
        go();
        chk("R2 pc0", pc_o, 32'd0);
        exp_wb("R4 addi pos", 5'd1, 32'd5);
        step(); exp_wb("R4 addi neg sext", 5'd2, 32'hFFFF_FFFD);
        step(); exp_wb("R3 add", 5'd3, 32'd2);
        step(); exp_wb("R3 sub", 5'd4, 32'd8);
        step(); exp_wb("R3 and", 5'd5, 32'd5);
        step(); exp_wb("R3 or", 5'd6, 32'hFFFF_FFFD);
        step(); exp_wb("R3 slt signed true", 5'd7, 32'd1);
        step(); exp_wb("R3 slt signed false", 5'd7, 32'd0);
        chk("R2 pc7", pc_o, 32'd28);
        step();
        chk("R5 sw we", {31'd0, dm_we_o}, 32'd1);
        chk("R5 sw addr", dm_addr_o, 32'd8);
        chk("R5 sw data", dm_wdata_o, 32'd2);
        chk("R5 sw no rf", {31'd0, rf_we_o}, 32'd0);
        step(); exp_wb("R5 lw", 5'd8, 32'd2);
        step();
        step(); exp_wb("R7 r0 reads zero", 5'd9, 32'd0);
        step();
        chk("R8 unknown op no rf", {31'd0, rf_we_o}, 32'd0);
        chk("R8 unknown op no dm", {31'd0, dm_we_o}, 32'd0);
        step();
        chk("R8 unknown funct no rf", {31'd0, rf_we_o}, 32'd0);
        step();
        chk("R8 pc advances", pc_o, 32'd56);
    endtask

    // Reset clears registers and data memory
    task automatic t_reset_clear();
        restart();
        put(0, enc_i(6'b100011, 0, 1, 16'd8));
        put(1, enc_r(8, 8, 2, 6'b100000));
        go();
        exp_wb("R1 dmem cleared", 5'd1, 32'd0);
        step(); exp_wb("R1 regs cleared", 5'd2, 32'd0);
    endtask

    task automatic t_branch();
        restart();
        load_branch_prog();
        go(); step(); step();
        chk("R6 beq equal taken", {31'd0, br_taken_o}, 32'd1);
        step();
        chk("R6 beq target", pc_o, 32'd24);
        chk("R6 bne equal not taken", {31'd0, br_taken_o}, 32'd0);
        step(); chk("R6 bne fallthrough", pc_o, 32'd28);
        step();
        chk("R6 bne differ taken", {31'd0, br_taken_o}, 32'd1);
        step();
        chk("R6 bne target", pc_o, 32'd40);
        chk("R6 beq differ not taken", {31'd0, br_taken_o}, 32'd0);
        step(); chk("R6 beq fallthrough", pc_o, 32'd44);
    endtask

    task automatic t_flt_dst();
        restart();
        put(0, enc_i(6'b001000, 0, 1, 16'd5));
        put(1, enc_i(6'b001000, 0, 2, 16'd6));
        put(2, enc_r(1, 2, 3, 6'b100000));
        flt_force = 4'b0001; flt_value = 4'b0000;
        go(); step(); step();
        exp_wb("R9 dst stuck0 rtype to rt", 5'd2, 32'd11);
        restart();
        put(0, enc_i(6'b001000, 0, 1, 16'h1005));
        flt_force = 4'b0001; flt_value = 4'b0001;
        go();
        exp_wb("R9 dst stuck1 addi to rd", 5'd2, 32'h0000_1005);
    endtask

    task automatic t_flt_opb();
        restart();
        put(0, enc_i(6'b001000, 0, 1, 16'd5));
        flt_force = 4'b0010; flt_value = 4'b0000;
        go();
        exp_wb("R9 opb stuck0 addi uses rt", 5'd1, 32'd0);
        restart();
        put(0, enc_i(6'b001000, 0, 1, 16'd5));
        put(1, enc_r(1, 1, 3, 6'b100000));
        flt_force = 4'b0010; flt_value = 4'b0010;
        go(); step();
        exp_wb("R9 opb stuck1 rtype uses imm", 5'd3, 32'h0000_1825);
    endtask

    task automatic t_flt_wb();
        restart();
        put(0, enc_i(6'b001000, 0, 1, 16'd4));
        flt_force = 4'b0100; flt_value = 4'b0100;
        go();
        exp_wb("R10 wb stuck1 addi reads mem", 5'd1, 32'd0);
        restart();
        put(0, enc_i(6'b001000, 0, 1, 16'd9));
        put(1, enc_i(6'b101011, 0, 1, 16'd0));
        put(2, enc_i(6'b100011, 0, 2, 16'd0));
        flt_force = 4'b0100; flt_value = 4'b0000;
        go(); step(); step();
        exp_wb("R10 wb stuck0 lw gets address", 5'd2, 32'd0);
    endtask

    task automatic t_flt_zero();
        restart();
        load_branch_prog();
        flt_force = 4'b1000; flt_value = 4'b0000;
        go(); step(); step();
        chk("R10 zero stuck0 beq not taken", {31'd0, br_taken_o}, 32'd0);
        step(); chk("R10 zero stuck0 fallthrough", pc_o, 32'd12);
        restart();
        load_branch_prog();
        flt_force = 4'b1000; flt_value = 4'b1000;
        go(); step(); step();
        chk("R10 zero stuck1 beq taken", {31'd0, br_taken_o}, 32'd1);
        step(); step(); step();
        chk("R10 zero stuck1 pc at bne", pc_o, 32'd32);
        chk("R10 zero stuck1 bne not taken", {31'd0, br_taken_o}, 32'd0);
        step(); chk("R10 zero stuck1 fallthrough", pc_o, 32'd36);
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_arith();
        t_reset_clear();
        t_branch();
        t_flt_dst();
        t_flt_opb();
        t_flt_wb();
        t_flt_zero();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule